// File: doc/BRIEF.md
# Scaled Masked Softmax Unit

This block turns one row of attention scores into a row of probabilities. Scores arrive one per handshake on a valid/ready stream, each a signed 16-bit fixed-point value with 8 fraction bits. Every score is multiplied by a build-time constant equal to the reciprocal square root of the key dimension. The scaled value then passes through a piecewise-linear exponential. An optional causal mask forces the exponential of every key position after the query position to zero.

Each exponential is stored in a row buffer while a running sum is built. After the last score of the row, the input stalls. A sequential restoring divider then divides each stored exponential by the sum and emits one probability per element, in arrival order. The next row is accepted only after that pass ends. Probabilities are unsigned 16-bit values with 15 fraction bits, so 32768 stands for 1.0.

Top module: `attn_softmax`

## Requirements
- R1: While reset is held and right after it, `score_ready_o` is 1 and `prob_valid_o` and `prob_last_o` are 0.
- R2: A score s (signed Q7.8) is scaled to x = floor(s * SCALE_Q / 65536), where SCALE_Q is an unsigned Q0.16 parameter (default 8192, that is 1/8, for a key dimension of 64).
- R3: The exponential e(x), in Q1.15, is 32768 for x >= 0 and 0 for x below -8.0 (x < -2048 in Q.8). Between those limits, [-8, 0) is split into 8 segments of width 1.0. Each segment interpolates linearly between the node values e^-k = 32768, 12055, 4435, 1631, 600, 221, 81, 30, 11 for k = 0..8, computed as left + floor((right - left) * frac / 256), where frac is the low 8 bits of x + 2048.
- R4: Row length, query index and mask enable are sampled together with the first score of a row. Positions count from 0 in arrival order. With the mask enabled, every position greater than the query index contributes 0 to both the sum and its own output. With the mask disabled, the query index has no effect.
- R5: The output for position k is floor(e_k * 32768 / S), where S is the sum of the row's exponentials.
- R6: A row of length n (1 to 64) yields exactly n outputs, in arrival order. `prob_last_o` is 1 only together with the n-th output.
- R7: `score_ready_o` is 0 from the cycle after the last score of a row is accepted until the cycle after the last output. It is 1 again on the following cycle.
- R8: If the row sum is 0, every output of that row is 0.
- R9: Every output is at most 32768, and the outputs of one row add up to at most 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| score_i | input | SCORE_W | Signed score, Q7.8 |
| score_valid_i | input | 1 | Score present |
| score_ready_o | output | 1 | Score accepted when high with valid |
| row_len_i | input | clog2(MAX_LEN+1) | Elements in the row, sampled with the first score |
| query_idx_i | input | clog2(MAX_LEN) | Query position, sampled with the first score |
| mask_en_i | input | 1 | Causal mask enable, sampled with the first score |
| prob_o | output | EXP_W | Probability, Q1.15 |
| prob_valid_o | output | 1 | One-cycle strobe per output element |
| prob_last_o | output | 1 | Marks the final output of the row |

## Verification
A wrong segment pick or interpolation term in the exponential shifts every probability of the row. This shows on the first output after the divide pass starts, about 33 cycles after the last score. A bad mask compare or a stale sampled length appears as a nonzero probability at a masked position, or as a wrong count of strobes before the last marker. A divider that keeps remainder state from the previous element, or a sum that is not cleared between rows, corrupts the second element of a row or every element of the next row. Both are caught on the first output they touch.

// File: rtl/smx_pkg.sv
package smx_pkg;
  localparam int unsigned EXP_ONE = 32768;
  localparam int unsigned SEG_CNT = 8;

  typedef enum logic [1:0] {ST_ACC, ST_FIN, ST_DIV, ST_END} smx_state_e;

  // exp(-k) in Q1.15, node ROM of the piecewise-linear exponential
  function automatic logic [15:0] exp_node(logic [3:0] k);
    case (k)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd12055;
      4'd2:    return 16'd4435;
      4'd3:    return 16'd1631;
      4'd4:    return 16'd600;
      4'd5:    return 16'd221;
      4'd6:    return 16'd81;
      4'd7:    return 16'd30;
      4'd8:    return 16'd11;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/smx_scale_stage.sv
module smx_scale_stage #(
  parameter int unsigned SCORE_W = 16,
  parameter int unsigned SCALE_W = 16,
  parameter int unsigned SCALE_Q = 8192,
  parameter int unsigned X_W     = 18,
  parameter int unsigned IDX_W   = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic signed [SCORE_W-1:0] score_i,
  input  logic [IDX_W-1:0]          pos_i,
  input  logic                      masked_i,
  input  logic                      last_i,
  output logic                      valid_o,
  output logic signed [X_W-1:0]     x_o,
  output logic [IDX_W-1:0]          pos_o,
  output logic                      masked_o,
  output logic                      last_o
);
  localparam int unsigned P_W = SCORE_W + SCALE_W + 1;
  localparam logic signed [SCALE_W:0] SCALE_S = {1'b0, SCALE_W'(SCALE_Q)};

  logic signed [P_W-1:0] prod;
  logic signed [X_W-1:0] x_d;

  assign prod = $signed(score_i) * SCALE_S;
  assign x_d  = X_W'(prod >>> SCALE_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      x_o      <= '0;
      pos_o    <= '0;
      masked_o <= 1'b0;
      last_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        x_o      <= x_d;
        pos_o    <= pos_i;
        masked_o <= masked_i;
        last_o   <= last_i;
      end
    end
  end
endmodule

// File: rtl/smx_pwl_exp.sv
module smx_pwl_exp
  import smx_pkg::*;
#(
  parameter int unsigned X_W    = 18,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned EXP_W  = 16
) (
  input  logic signed [X_W-1:0] x_i,
  output logic [EXP_W-1:0]      e_o
);
  localparam int RANGE = int'(SEG_CNT) << FRAC_W;

  always_comb begin
    int xi, t, seg, frac, lo, hi, ev;
    xi   = int'(x_i);
    t    = xi + RANGE;
    seg  = t >>> FRAC_W;
    frac = t & ((1 << FRAC_W) - 1);
    lo   = 0;
    hi   = 0;
    if (xi >= 0) begin
      ev = int'(EXP_ONE);
    end else if (xi < -RANGE) begin
      ev = 0;
    end else begin
      lo = int'(exp_node(4'(int'(SEG_CNT) - seg)));
      hi = int'(exp_node(4'(int'(SEG_CNT) - 1 - seg)));
      ev = lo + (((hi - lo) * frac) >>> FRAC_W);
    end
    e_o = EXP_W'(ev);
  end
endmodule

// File: rtl/smx_divider.sv
module smx_divider #(
  parameter int unsigned N_W = 31,
  parameter int unsigned D_W = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] dividend_i,
  input  logic [D_W-1:0] divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N_W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   rem_q, div_q, nxt_rem;
  logic [N_W-1:0]   num_q;
  logic [CNT_W-1:0] cnt_q;
  logic [D_W:0]     trial;
  logic             qbit;

  always_comb begin
    trial   = {rem_q, num_q[N_W-1]};
    qbit    = (trial >= {1'b0, div_q});
    nxt_rem = qbit ? D_W'(trial - {1'b0, div_q}) : D_W'(trial);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      div_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      div_q  <= divisor_i;
      num_q  <= dividend_i;
      cnt_q  <= CNT_W'(N_W);
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_o) begin
      rem_q  <= nxt_rem;
      num_q  <= {num_q[N_W-2:0], qbit};
      cnt_q  <= cnt_q - 1'b1;
      busy_o <= (cnt_q != CNT_W'(1));
      done_o <= (cnt_q == CNT_W'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = num_q;

  // R5: restoring step keeps the partial remainder below the divisor
  a_r5_rem_below_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rem_q < div_q));
  a_r5_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/attn_softmax.sv
module attn_softmax
  import smx_pkg::*;
#(
  parameter int unsigned SCORE_W    = 16,
  parameter int unsigned SCORE_FRAC = 8,
  parameter int unsigned SCALE_W    = 16,
  parameter int unsigned SCALE_Q    = 8192,
  parameter int unsigned MAX_LEN    = 64,
  parameter int unsigned EXP_W      = 16,
  parameter int unsigned PROB_FRAC  = 15
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic signed [SCORE_W-1:0]    score_i,
  input  logic                         score_valid_i,
  output logic                         score_ready_o,
  input  logic [$clog2(MAX_LEN+1)-1:0] row_len_i,
  input  logic [$clog2(MAX_LEN)-1:0]   query_idx_i,
  input  logic                         mask_en_i,
  output logic [EXP_W-1:0]             prob_o,
  output logic                         prob_valid_o,
  output logic                         prob_last_o
);
  localparam int unsigned IDX_W = $clog2(MAX_LEN);
  localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);
  localparam int unsigned SUM_W = EXP_W + IDX_W;
  localparam int unsigned DIV_W = EXP_W + PROB_FRAC;
  localparam int unsigned X_W   = SCORE_W + 2;
  localparam logic [EXP_W-1:0] ONE_E = EXP_W'(EXP_ONE);

  smx_state_e        state_q;
  logic [IDX_W-1:0]  pos_q, qidx_q, out_idx_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              mask_q, div_run_q;
  logic [SUM_W-1:0]  sum_q;

  logic              accept, first, in_last, in_masked, eff_mask;
  logic [LEN_W-1:0]  eff_len;
  logic [IDX_W-1:0]  eff_qidx;

  logic              s1_valid, s1_masked, s1_last;
  logic signed [X_W-1:0] s1_x;
  logic [IDX_W-1:0]  s1_pos;
  logic [EXP_W-1:0]  e_raw, e_sel, rd_e;
  logic [EXP_W-1:0]  buf_q [MAX_LEN];

  logic              div_start, div_busy, div_done, sum_zero, out_last;
  logic [DIV_W-1:0]  quot;
  logic [EXP_W-1:0]  quot_sat;

  assign score_ready_o = (state_q == ST_ACC);
  assign accept        = score_valid_i && score_ready_o;
  assign first         = (pos_q == '0);
  assign eff_len       = first ? row_len_i   : len_q;
  assign eff_qidx      = first ? query_idx_i : qidx_q;
  assign eff_mask      = first ? mask_en_i   : mask_q;
  assign in_last       = ((LEN_W'(pos_q) + LEN_W'(1)) >= eff_len) ||
                         (pos_q == IDX_W'(MAX_LEN - 1));
  assign in_masked     = eff_mask && (pos_q > eff_qidx);

  smx_scale_stage #(
    .SCORE_W(SCORE_W), .SCALE_W(SCALE_W), .SCALE_Q(SCALE_Q),
    .X_W(X_W), .IDX_W(IDX_W)
  ) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(accept), .score_i(score_i), .pos_i(pos_q),
    .masked_i(in_masked), .last_i(in_last),
    .valid_o(s1_valid), .x_o(s1_x), .pos_o(s1_pos),
    .masked_o(s1_masked), .last_o(s1_last)
  );

  smx_pwl_exp #(.X_W(X_W), .FRAC_W(SCORE_FRAC), .EXP_W(EXP_W)) u_exp (
    .x_i(s1_x), .e_o(e_raw)
  );

  // causal mask as a select on the exponential
  assign e_sel = s1_masked ? '0 : e_raw;

  always_ff @(posedge clk_i) begin
    if (s1_valid) buf_q[s1_pos] <= e_sel;
  end

  assign rd_e      = buf_q[out_idx_q];
  assign sum_zero  = (sum_q == '0);
  assign out_last  = ((LEN_W'(out_idx_q) + LEN_W'(1)) == cnt_q);
  assign div_start = (state_q == ST_DIV) && !div_run_q && !sum_zero && !div_busy;

  smx_divider #(.N_W(DIV_W), .D_W(SUM_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dividend_i({rd_e, PROB_FRAC'(0)}), .divisor_i(sum_q),
    .busy_o(div_busy), .done_o(div_done), .quot_o(quot)
  );

  assign quot_sat = (|quot[DIV_W-1:EXP_W]) ? ONE_E : quot[EXP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_ACC;
      pos_q        <= '0;
      len_q        <= '0;
      qidx_q       <= '0;
      mask_q       <= 1'b0;
      cnt_q        <= '0;
      sum_q        <= '0;
      out_idx_q    <= '0;
      div_run_q    <= 1'b0;
      prob_o       <= '0;
      prob_valid_o <= 1'b0;
      prob_last_o  <= 1'b0;
    end else begin
      prob_valid_o <= 1'b0;
      prob_last_o  <= 1'b0;
      if (accept) begin
        if (first) begin
          len_q  <= row_len_i;
          qidx_q <= query_idx_i;
          mask_q <= mask_en_i;
        end
        if (in_last) begin
          pos_q   <= '0;
          cnt_q   <= LEN_W'(pos_q) + LEN_W'(1);
          state_q <= ST_FIN;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
      if (s1_valid) begin
        sum_q <= sum_q + SUM_W'(e_sel);
        if (s1_last) begin
          state_q   <= ST_DIV;
          out_idx_q <= '0;
          div_run_q <= 1'b0;
        end
      end
      case (state_q)
        ST_DIV: begin
          if ((!div_run_q && sum_zero) || (div_run_q && div_done)) begin
            prob_o       <= div_run_q ? quot_sat : '0;
            prob_valid_o <= 1'b1;
            prob_last_o  <= out_last;
            div_run_q    <= 1'b0;
            if (out_last) state_q <= ST_END;
            else          out_idx_q <= out_idx_q + 1'b1;
          end else if (div_start) begin
            div_run_q <= 1'b1;
          end
        end
        ST_END: begin
          sum_q   <= '0;
          state_q <= ST_ACC;
        end
        default: ;
      endcase
    end
  end

  a_r3_exp_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> (e_raw <= ONE_E));
  a_r7_ready_low_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prob_valid_o |-> !score_ready_o);
  a_r9_prob_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prob_valid_o |-> (prob_o <= ONE_E));
  a_r8_zero_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prob_valid_o && sum_zero) |-> (prob_o == '0));
  a_r6_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prob_last_o |-> prob_valid_o);
  a_r5_sum_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV && $past(state_q == ST_DIV)) |-> $stable(sum_q));
endmodule

// File: tb/attn_softmax_tb_top.sv
module attn_softmax_tb_top;
  localparam int SCALE = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] score;
  logic        sv;
  logic        ready;
  logic [6:0]  len;
  logic [5:0]  qidx;
  logic        men;
  logic [15:0] prob;
  logic        pv, pl;

  int total = 0;
  int bad   = 0;
  int sc[64];
  int nodes[9] = '{32768, 12055, 4435, 1631, 600, 221, 81, 30, 11};

  always #10 clk = ~clk;

  attn_softmax dut_i (
    .clk_i(clk), .rst_ni(rst_n), .score_i(score), .score_valid_i(sv),
    .score_ready_o(ready), .row_len_i(len), .query_idx_i(qidx),
    .mask_en_i(men), .prob_o(prob), .prob_valid_o(pv), .prob_last_o(pl)
  );

  function automatic int f_scale(int s);
    longint p = longint'(s) * SCALE;
    return int'(p >>> 16);
  endfunction

  function automatic int f_exp(int x);
    int t, s, f, l, r;
    if (x >= 0) return 32768;
    if (x < -2048) return 0;
    t = x + 2048;
    s = t / 256;
    f = t % 256;
    l = nodes[8 - s];
    r = nodes[7 - s];
    return l + ((r - l) * f) / 256;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_row(int n, int q, bit m);
    int e[64];
    int sum = 0;
    int psum = 0;
    for (int k = 0; k < n; k++) begin
      e[k] = (m && k > q) ? 0 : f_exp(f_scale(sc[k]));
      sum += e[k];
    end
    @(negedge clk);
    len = 7'(n); qidx = 6'(q); men = m;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        sv = 1'b0;
        @(negedge clk);
      end
      sv = 1'b1;
      score = 16'(sc[k]);
      while (!ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    sv = 1'b0;
    for (int k = 0; k < n; k++) begin
      int expv;
      while (!pv) @(negedge clk);
      expv = (sum == 0) ? 0 : int'((longint'(e[k]) * 32768) / sum);
      check(ready == 1'b0, "R7", int'(ready), 0);
      if (m && k > q)     check(prob == 16'(expv), "R4", int'(prob), expv);
      else if (sum == 0)  check(prob == 16'(expv), "R8", int'(prob), expv);
      else                check(prob == 16'(expv), "R2 R3 R5", int'(prob), expv);
      check(pl == (k == n - 1), "R6", int'(pl), int'(k == n - 1));
      psum += int'(prob);
      @(negedge clk);
    end
    check(psum <= 32768, "R9", psum, 32768);
    check(pv == 1'b0, "R6", int'(pv), 0);
    check(ready == 1'b1, "R7", int'(ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R6 watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sv = 1'b0; score = '0; len = 7'd1; qidx = '0; men = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1", int'(ready), 1);
    check(pv == 1'b0 && pl == 1'b0, "R1", int'(pv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && pv == 1'b0, "R1", int'(ready), 1);

    // single element at x = 0 gives exactly one (R3 saturation, R6)
    sc[0] = 0;
    run_row(1, 0, 1'b0);
    // node at x = -8 beside a saturated value (R3 boundary)
    sc[0] = -16384; sc[1] = 0;
    run_row(2, 1, 1'b0);
    // everything below the range: zero sum (R8)
    for (int k = 0; k < 5; k++) sc[k] = -32768;
    run_row(5, 4, 1'b0);
    // causal mask against the same data unmasked (R4)
    for (int k = 0; k < 8; k++) sc[k] = -2000 + k * 300;
    run_row(8, 3, 1'b1);
    run_row(8, 3, 1'b0);
    // mask leaves only position 0
    run_row(8, 0, 1'b1);
    // full length row (R6)
    for (int k = 0; k < 64; k++) sc[k] = int'($urandom_range(0, 20000)) - 16000;
    run_row(64, 40, 1'b1);
    // random rows
    for (int r = 0; r < 18; r++) begin
      int n, q;
      n = int'($urandom_range(1, 64));
      q = int'($urandom_range(0, n - 1));
      for (int k = 0; k < n; k++) sc[k] = int'($urandom_range(0, 24000)) - 20000;
      run_row(n, q, 1'($urandom_range(0, 1)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule